// File: doc/BRIEF.md
# Serial Operand Subtract-and-Scale Sequencer

This block is a clocked sequencer that drives two external 8-bit universal shift registers. The controller sits idle with both registers frozen. When a start request arrives, it tells both registers to take their operands in parallel. It then shifts both operands out of the registers in lockstep and assembles them inside.

Next it forms the difference of the second operand minus the first and divides it, signed, by eight. It raises an overflow flag when that difference cannot be held in eight bits. Last, it streams the 8-bit quotient serially back into the first shift register. Status flags report each phase: idle, operand load and result load.

The block is meant to sit between a pair of switch-loaded shift registers and a display. Every register mode is commanded by the block, so the surrounding logic only has to hold the operands on the parallel inputs and pulse start.

Top module: `sop_ctrl`

## Requirements
- R1: After reset, done_o=1, ovf_o=0, op_ld_o=0, res_ld_o=0, and both mode outputs are 2'b00. The mode encoding is hold=2'b00, shift-right=2'b01 and parallel-load=2'b11.
- R2: While done_o=1 and start_i=0, clock edges change no output. Both mode outputs stay at hold, so the contents of shift register 1 are kept.
- R3: start_i sampled high while done_o=1 gives, in the next cycle, done_o=0 and op_ld_o=1, with both mode outputs at 2'b11 for exactly that one cycle.
- R4: The load cycle is followed by exactly 8 cycles with both modes at 2'b01 and op_ld_o=1. In each of these cycles one bit is taken from each serial input, least significant bit first. start_i has no effect from the load cycle until done_o rises again.
- R5: After capture, op_ld_o drops and both modes hold for one cycle. The result is the quotient of (operand 2 - operand 1) / 8, formed from the exact difference and truncated toward zero, as an 8-bit two's complement value.
- R6: The result then leaves on res_ser_o, least significant bit first, over 8 cycles. During these cycles res_ld_o=1, mode 1 is 2'b01 and mode 2 is 2'b00. done_o rises 19 cycles after the edge that accepted start, and shift register 1 then holds the result.
- R7: ovf_o goes low in the cycle that follows the start acceptance. It goes high in the first result cycle if, and only if, operand 2 - operand 1 lies outside -128..127. It then holds its value until the next start.
- R8: Driving rst_ni low forces the R1 state at once, without waiting for a clock edge, from any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, synchronous to clk_i |
| sr1_ser_i | input | 1 | Serial output of shift register 1 (operand 1) |
| sr2_ser_i | input | 1 | Serial output of shift register 2 (operand 2) |
| sr1_mode_o | output | 2 | Mode command for shift register 1 |
| sr2_mode_o | output | 2 | Mode command for shift register 2 |
| res_ser_o | output | 1 | Serial result bit into shift register 1 |
| done_o | output | 1 | Idle / operation complete |
| ovf_o | output | 1 | Difference overflow flag |
| op_ld_o | output | 1 | Operand load phase active |
| res_ld_o | output | 1 | Result load phase active |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and a divide shift of 3. These values put the full two's complement operand range within reach, including both overflow extremes: -128 minus 127 and 127 minus -128. They also reach the small negative differences where truncation toward zero differs from a plain arithmetic shift. Random operand pairs are mixed with these directed cases. A start that stays high past acceptance and a reset in mid-shift exercise the handshake corners.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    SR_HOLD = 2'b00,
    SR_SHR  = 2'b01,
    SR_LOAD = 2'b11
  } sr_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIN,
    ST_CALC,
    ST_SHOUT
  } seq_state_e;
endpackage

// File: rtl/sop_seq.sv
module sop_seq
  import sop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output seq_state_e state_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  seq_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_SHIN;
          cnt_q   <= '0;
        end
        ST_SHIN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_CALC;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CALC:  state_q <= ST_SHOUT;
        ST_SHOUT: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sop_deser.sv
module sop_deser #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  // LSB arrives first; fill from the MSB end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (en_i) data_q <= {bit_i, data_q[DATA_W-1:1]};
  end

  assign data_o = data_q;
endmodule

// File: rtl/sop_alu.sv
module sop_alu #(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 3
) (
  input  logic [DATA_W-1:0] op1_i,
  input  logic [DATA_W-1:0] op2_i,
  output logic [DATA_W-1:0] quo_o,
  output logic              ovf_o
);
  localparam int EXT_W = DATA_W + 1;
  localparam int PAD_W = DATA_W - (EXT_W - SHIFT);
  localparam logic [EXT_W-1:0] BIAS = EXT_W'((1 << SHIFT) - 1);

  logic [EXT_W-1:0] diff;
  logic [EXT_W-1:0] biased;
  logic             unused_low;

  assign diff   = {op2_i[DATA_W-1], op2_i} - {op1_i[DATA_W-1], op1_i};
  // bias negative values so the shift truncates toward zero
  assign biased = diff + (diff[EXT_W-1] ? BIAS : '0);
  assign quo_o  = {{PAD_W{biased[EXT_W-1]}}, biased[EXT_W-1:SHIFT]};
  assign ovf_o  = diff[EXT_W-1] ^ diff[DATA_W-1];
  assign unused_low = ^biased[SHIFT-1:0];
endmodule

// File: rtl/sop_ser.sv
module sop_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_i)  data_q <= data_i;
    else if (shift_i) data_q <= {1'b0, data_q[DATA_W-1:1]};
  end

  assign bit_o = data_q[0];
endmodule

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_SHIFT = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sr1_ser_i,
  input  logic       sr2_ser_i,
  output logic [1:0] sr1_mode_o,
  output logic [1:0] sr2_mode_o,
  output logic       res_ser_o,
  output logic       done_o,
  output logic       ovf_o,
  output logic       op_ld_o,
  output logic       res_ld_o
);
  localparam int NUM_OPS = 2;

  seq_state_e        state;
  logic [NUM_OPS-1:0] ser_in;
  logic [DATA_W-1:0] opnd [NUM_OPS];
  logic [DATA_W-1:0] quo;
  logic              ovf_calc;
  logic              ovf_q;
  sr_mode_e          mode1, mode2;

  assign ser_in = {sr2_ser_i, sr1_ser_i};

  sop_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state)
  );

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_opnd
    sop_deser #(.DATA_W(DATA_W)) u_deser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (state == ST_SHIN),
      .bit_i  (ser_in[i]),
      .data_o (opnd[i])
    );
  end

  sop_alu #(.DATA_W(DATA_W), .SHIFT(DIV_SHIFT)) u_alu (
    .op1_i (opnd[0]),
    .op2_i (opnd[1]),
    .quo_o (quo),
    .ovf_o (ovf_calc)
  );

  sop_ser #(.DATA_W(DATA_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state == ST_CALC),
    .shift_i (state == ST_SHOUT),
    .data_i  (quo),
    .bit_o   (res_ser_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovf_q <= 1'b0;
    else if (state == ST_IDLE && start_i)  ovf_q <= 1'b0;
    else if (state == ST_CALC)             ovf_q <= ovf_calc;
  end

  always_comb begin
    mode1 = SR_HOLD;
    mode2 = SR_HOLD;
    unique case (state)
      ST_LOAD:  begin mode1 = SR_LOAD; mode2 = SR_LOAD; end
      ST_SHIN:  begin mode1 = SR_SHR;  mode2 = SR_SHR;  end
      ST_SHOUT: mode1 = SR_SHR;
      default:  ;
    endcase
  end

  assign sr1_mode_o = mode1;
  assign sr2_mode_o = mode2;
  assign done_o     = (state == ST_IDLE);
  assign op_ld_o    = (state == ST_LOAD) || (state == ST_SHIN);
  assign res_ld_o   = (state == ST_SHOUT);
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/sop_ctrl_chk.sv
module sop_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] sr1_mode_o,
  input logic [1:0] sr2_mode_o,
  input logic       done_o,
  input logic       ovf_o,
  input logic       op_ld_o,
  input logic       res_ld_o
);
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sr1_mode_o == 2'b00 && sr2_mode_o == 2'b00 && !op_ld_o && !res_ld_o));

  // R2
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(ovf_o)));

  // R3
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && op_ld_o && sr1_mode_o == 2'b11 && sr2_mode_o == 2'b11));

  // R4
  load_then_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr1_mode_o == 2'b11) |=> (op_ld_o && sr1_mode_o == 2'b01 && sr2_mode_o == 2'b01));

  // R6
  result_modes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ld_o |-> (sr1_mode_o == 2'b01 && sr2_mode_o == 2'b00));

  // R6
  result_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(res_ld_o) |-> done_o);

  // R5
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, op_ld_o, res_ld_o}));

  // R7
  ovf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_ld_o && !$rose(op_ld_o)) |-> !ovf_o);
endmodule

bind sop_ctrl sop_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .sr1_mode_o (sr1_mode_o),
  .sr2_mode_o (sr2_mode_o),
  .done_o     (done_o),
  .ovf_o      (ovf_o),
  .op_ld_o    (op_ld_o),
  .res_ld_o   (res_ld_o)
);

// File: tb/tb_sop_ctrl.sv
module tb_sop_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [7:0] sw1 = '0, sw2 = '0;
  logic [7:0] sr1 = '0, sr2 = '0;
  logic [1:0] m1, m2;
  logic res_ser, done, ovf, op_ld, res_ld;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sop_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .sr1_ser_i(sr1[0]), .sr2_ser_i(sr2[0]),
    .sr1_mode_o(m1), .sr2_mode_o(m2), .res_ser_o(res_ser),
    .done_o(done), .ovf_o(ovf), .op_ld_o(op_ld), .res_ld_o(res_ld)
  );

  // behavioural external shift registers
  always_ff @(posedge clk) begin
    case (m1)
      2'b11: sr1 <= sw1;
      2'b01: sr1 <= {res_ser, sr1[7:1]};
      default: ;
    endcase
    case (m2)
      2'b11: sr2 <= sw2;
      2'b01: sr2 <= {1'b0, sr2[7:1]};
      default: ;
    endcase
  end

  function automatic int diff_of(logic [7:0] a, logic [7:0] b);
    return int'($signed(b)) - int'($signed(a));
  endfunction

  function automatic logic [7:0] exp_res(logic [7:0] a, logic [7:0] b);
    int q;
    q = diff_of(a, b) / 8;
    return q[7:0];
  endfunction

  function automatic logic exp_ovf(logic [7:0] a, logic [7:0] b);
    int d;
    d = diff_of(a, b);
    return (d > 127) || (d < -128);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(done == 1'b1, req, "done", int'(done), 1);
    check(ovf == 1'b0 && op_ld == 1'b0 && res_ld == 1'b0, req, "ovf/op_ld/res_ld",
          int'({ovf, op_ld, res_ld}), 0);
    check(m1 == 2'b00 && m2 == 2'b00, req, "modes", int'({m1, m2}), 0);
  endtask

  task automatic run_op(logic [7:0] a, logic [7:0] b, int hold);
    int cyc = 0;
    logic [7:0] er;
    logic eo;
    er = exp_res(a, b);
    eo = exp_ovf(a, b);
    @(negedge clk);
    sw1 = a; sw2 = b; start = 1'b1;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc >= hold) start = 1'b0;
      if (cyc == 1) begin
        // R3: load cycle
        check(!done && op_ld && m1 == 2'b11 && m2 == 2'b11, "R3", "load phase",
              int'({done, op_ld, m1, m2}), int'(6'b011111));
        // R7: flag cleared after acceptance
        check(ovf == 1'b0, "R7", "ovf cleared", int'(ovf), 0);
      end
      if (cyc == 2 || cyc == 9)
        check(op_ld && m1 == 2'b01 && m2 == 2'b01, "R4", "shift-in phase",
              int'({op_ld, m1, m2}), int'(5'b10101));
      if (cyc == 10)
        check(!op_ld && !res_ld && m1 == 2'b00 && m2 == 2'b00, "R5", "calc cycle",
              int'({op_ld, res_ld, m1, m2}), 0);
      if (cyc == 11 || cyc == 18)
        check(res_ld && m1 == 2'b01 && m2 == 2'b00, "R6", "shift-out phase",
              int'({res_ld, m1, m2}), int'(5'b10100));
      if (done || cyc >= 40) break;
    end
    start = 1'b0;
    check(cyc == 19, "R6", "cycles to done", cyc, 19);
    check(sr1 == er, "R5", $sformatf("result a=%0d b=%0d", $signed(a), $signed(b)),
          int'($signed(sr1)), int'($signed(er)));
    check(ovf == eo, "R7", $sformatf("ovf a=%0d b=%0d", $signed(a), $signed(b)),
          int'(ovf), int'(eo));
  endtask

  task automatic idle_hold();
    logic [7:0] keep_sr1;
    logic keep_ovf;
    keep_sr1 = sr1;
    keep_ovf = ovf;
    sw1 = ~sw1; sw2 = ~sw2;
    repeat (4) @(negedge clk);
    check(done && sr1 == keep_sr1 && ovf == keep_ovf, "R2", "idle hold",
          int'({done, sr1, ovf}), int'({1'b1, keep_sr1, keep_ovf}));
    check(m1 == 2'b00 && m2 == 2'b00 && !op_ld && !res_ld, "R2", "idle outputs",
          int'({m1, m2, op_ld, res_ld}), 0);
  endtask

  initial begin
    void'($urandom(32'd20081));
    #35;
    check_idle("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R2");

    // directed corners
    run_op(8'd0,   8'd0,   1);
    run_op(8'h80,  8'h7F,  1);   // +255: overflow
    idle_hold();
    run_op(8'h7F,  8'h80,  1);   // -255: overflow
    run_op(8'd1,   8'hF9,  1);   // -8 -> -1
    run_op(8'd0,   8'hF9,  1);   // -7 -> 0
    run_op(8'd0,   8'hF1,  1);   // -15 -> -1
    run_op(8'd0,   8'd7,   1);
    run_op(8'hFF,  8'h7F,  1);   // 128: overflow
    run_op(8'd0,   8'h80,  1);   // -128: no overflow
    idle_hold();
    // R4: start held past acceptance
    run_op(8'h15,  8'hC3,  6);
    idle_hold();

    // R8: reset in mid-shift
    @(negedge clk);
    sw1 = 8'h33; sw2 = 8'h99; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    #3 rst_ni = 1'b0;
    #1 check_idle("R8");
    @(negedge clk);
    check_idle("R8");
    rst_ni = 1'b1;
    run_op(8'h33, 8'h99, 1);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      run_op(a, b, 1 + int'($urandom % 3));
      if (i % 8 == 0) idle_hold();
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule